// File: doc/BRIEF.md
# Host Command Packet Decoder for a Logic Analyzer

The block sits between the host link and the capture engine of a multi-channel logic analyzer. It takes a byte stream of fixed-length host packets. Each packet carries a two-byte header, the full acquisition setup and a two-byte command at its end. A packet whose header is correct and whose command is a start request commits the whole setup to the configuration outputs at once. A status or data request raises its own one-cycle strobe and leaves the setup untouched. A bad header or an unknown command costs the packet's 84 bytes and changes nothing.

A status request also makes the block send a 1024-byte reply on its output stream. The reply is a tag word, a snapshot of the live input pins, the capture state, an auxiliary word and a version word, followed by zeros. Both streams use valid/ready. On the input side a byte moves when `s_valid` and `s_ready` are both high. `s_ready` drops from the status strobe until the last reply byte has been taken, so a sender may hold its next byte on the input and it waits there. On the output side a byte moves when `m_valid` and `m_ready` are both high. While `m_ready` is low the offered byte and `m_last` stay unchanged.

Top module: `hostcmd_decoder`

## Requirements
- R1: After reset all configuration outputs, `cmd_code` and the three strobes are zero, `m_valid` is low and `s_ready` is high.
- R2: A packet is 84 accepted bytes and multi-byte fields are least significant byte first. The byte offsets are: 2 rate code, 3 trigger flags, 4-5 threshold A, 6-7 threshold B, 8 auxiliary parameter, 10-13 sample depth, 14-17 pretrigger depth, 18-49 trigger 1 (eight words), 50-81 trigger 2 and 82-83 command. Configuration outputs change only in the cycle after the last byte of a good start packet is accepted, and then all of them change together.
- R3: A packet whose byte 0 is not 0x7F or whose byte 1 is not 0x01 is consumed in full (84 bytes). It raises no strobe and changes no output.
- R4: Command bytes 0x1A then 0x2B raise `start_stb` for one cycle, set `cmd_code` to 0x1A2B and produce no reply.
- R5: Command bytes 0x3A then 0x4B raise `status_stb` for one cycle, set `cmd_code` to 0x3A4B and leave the configuration unchanged.
- R6: Command bytes 0x5A then 0x6B raise `data_stb` for one cycle, set `cmd_code` to 0x5A6B, leave the configuration unchanged and produce no reply.
- R7: Any other command code with a good header changes no output and raises no strobe.
- R8: `m_valid` rises in the cycle after `status_stb`. The reply is 1024 bytes with `m_last` on the final byte. Its 32-bit words go least significant byte first: 0x2B1A037F, the live-input snapshot, the status word (2 if `cap_done`, else 0), `aux_in`, the VERSION parameter, then zeros.
- R9: `live_in`, `cap_done` and `aux_in` are sampled in the `status_stb` cycle. Later changes do not alter the reply.
- R10: While `m_valid` is high and `m_ready` is low, `m_data` and `m_last` hold. `s_ready` is low from the `status_stb` cycle through the cycle in which the last reply byte is accepted, and input bytes offered then are held back, not lost.
- R11: `trig1_en`, `trig2_en` and `trig_and` equal bits 0, 1 and 2 of the latched trigger flags (AND when bit 2 is 1, OR when 0).
- R12: At most one strobe is high in any cycle, and no strobe is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_ready | output | 1 | Decoder can take a byte |
| m_valid | output | 1 | Reply byte valid |
| m_data | output | 8 | Reply byte |
| m_last | output | 1 | Final reply byte |
| m_ready | input | 1 | Sink takes reply byte |
| live_in | input | 32 | Live input pin state |
| cap_done | input | 1 | Capture finished |
| aux_in | input | 32 | Auxiliary status word |
| rate_code | output | 8 | Latched sample-rate code |
| trig_flags | output | 8 | Latched trigger flags |
| thr_a | output | 16 | Threshold word A |
| thr_b | output | 16 | Threshold word B |
| aux_param | output | 8 | Auxiliary parameter byte |
| sample_depth | output | 32 | Sample depth |
| pretrig_depth | output | 32 | Pretrigger depth |
| trig1_cfg | output | 256 | Trigger 1 setup, word 0 in bits 31:0 |
| trig2_cfg | output | 256 | Trigger 2 setup, word 0 in bits 31:0 |
| trig1_en | output | 1 | Trigger 1 enabled |
| trig2_en | output | 1 | Trigger 2 enabled |
| trig_and | output | 1 | Triggers combine by AND |
| cmd_code | output | 16 | Last recognised command, first byte high |
| start_stb | output | 1 | Start-capture strobe |
| status_stb | output | 1 | Status-request strobe |
| data_stb | output | 1 | Data-request strobe |

## Verification
The bench aims at packets that look close to valid but should be dropped. It sends start commands behind a bad header and a packet with an unknown command code. A decoder that checked only one header byte, or that committed fields as they arrived, would then show changed configuration outputs or raise strobes.

It sends a status request while the next packet is already being offered. A decoder that kept `s_ready` high during the reply would lose or misplace bytes of the second packet.

Random stalls on `m_ready` expose a reply counter that advances without a handshake. The live inputs change while the reply is being sent, which exposes a reply that reads the pins directly instead of a snapshot. Data requests and status requests placed between start packets show whether the setup is kept apart from the command field.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;
  localparam int PKT_BYTES   = 84;
  localparam int TRIG_WORDS  = 8;
  localparam int TRIG_BYTES  = TRIG_WORDS * 4;
  localparam int TRIG_BITS   = TRIG_BYTES * 8;
  localparam int OFF_RATE    = 2;
  localparam int OFF_FLAGS   = 3;
  localparam int OFF_THR_A   = 4;
  localparam int OFF_THR_B   = 6;
  localparam int OFF_PARAM   = 8;
  localparam int OFF_DEPTH   = 10;
  localparam int OFF_PRE     = 14;
  localparam int OFF_TRIG1   = 18;
  localparam int OFF_TRIG2   = OFF_TRIG1 + TRIG_BYTES;
  localparam int OFF_CMD     = OFF_TRIG2 + TRIG_BYTES;

  localparam logic [7:0]  HDR_B0     = 8'h7F;
  localparam logic [7:0]  HDR_B1     = 8'h01;
  localparam logic [15:0] CMD_START  = 16'h1A2B;
  localparam logic [15:0] CMD_STATUS = 16'h3A4B;
  localparam logic [15:0] CMD_DATA   = 16'h5A6B;
  localparam logic [31:0] REPLY_TAG  = 32'h2B1A037F;

  typedef enum logic [1:0] {
    CK_NONE, CK_START, CK_STATUS, CK_DATA
  } cmd_kind_e;

  typedef struct packed {
    logic [7:0]           rate;
    logic [7:0]           flags;
    logic [15:0]          thr_a;
    logic [15:0]          thr_b;
    logic [7:0]           param;
    logic [31:0]          depth;
    logic [31:0]          pretrig;
    logic [TRIG_BITS-1:0] trig1;
    logic [TRIG_BITS-1:0] trig2;
  } acq_cfg_t;
endpackage

// File: rtl/hc_frame_rx.sv
module hc_frame_rx
  import hostcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [7:0]  in_byte,
  output acq_cfg_t    cfg,
  output logic [15:0] cmd_code,
  output logic        start_stb,
  output logic        stat_stb,
  output logic        data_stb
);
  localparam int IDX_W = $clog2(PKT_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_BYTES - 1);

  logic [7:0]       shb [PKT_BYTES];
  logic [IDX_W-1:0] idx;
  logic             last_byte;
  logic             hdr_ok;
  logic [15:0]      cmd_now;
  cmd_kind_e        kind;
  acq_cfg_t         cfg_next;
  logic [TRIG_BITS-1:0] t1_flat, t2_flat;

  assign last_byte = take && (idx == IDX_LAST);
  assign hdr_ok    = (shb[0] == HDR_B0) && (shb[1] == HDR_B1);
  assign cmd_now   = {shb[OFF_CMD], in_byte};

  always_ff @(posedge clk) begin
    if (take) shb[idx] <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (take) idx <= last_byte ? '0 : idx + 1'b1;
  end

  always_comb begin
    kind = CK_NONE;
    if (hdr_ok) begin
      unique case (cmd_now)
        CMD_START:  kind = CK_START;
        CMD_STATUS: kind = CK_STATUS;
        CMD_DATA:   kind = CK_DATA;
        default:    kind = CK_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < TRIG_BYTES; i++) begin : g_trig
    assign t1_flat[8*i +: 8] = shb[OFF_TRIG1 + i];
    assign t2_flat[8*i +: 8] = shb[OFF_TRIG2 + i];
  end

  always_comb begin
    cfg_next.rate    = shb[OFF_RATE];
    cfg_next.flags   = shb[OFF_FLAGS];
    cfg_next.thr_a   = {shb[OFF_THR_A+1], shb[OFF_THR_A]};
    cfg_next.thr_b   = {shb[OFF_THR_B+1], shb[OFF_THR_B]};
    cfg_next.param   = shb[OFF_PARAM];
    cfg_next.depth   = {shb[OFF_DEPTH+3], shb[OFF_DEPTH+2],
                        shb[OFF_DEPTH+1], shb[OFF_DEPTH]};
    cfg_next.pretrig = {shb[OFF_PRE+3], shb[OFF_PRE+2],
                        shb[OFF_PRE+1], shb[OFF_PRE]};
    cfg_next.trig1   = t1_flat;
    cfg_next.trig2   = t2_flat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      cmd_code  <= '0;
      start_stb <= 1'b0;
      stat_stb  <= 1'b0;
      data_stb  <= 1'b0;
    end else begin
      start_stb <= last_byte && (kind == CK_START);
      stat_stb  <= last_byte && (kind == CK_STATUS);
      data_stb  <= last_byte && (kind == CK_DATA);
      if (last_byte && kind != CK_NONE) cmd_code <= cmd_now;
      if (last_byte && kind == CK_START) cfg <= cfg_next;
    end
  end

  // R2: configuration moves only together with a start strobe
  p_cfg_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> start_stb);
  // R4: start strobe carries the start command code
  p_start_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> cmd_code == CMD_START);
  // R5: status strobe carries the status command code
  p_stat_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_stb |-> cmd_code == CMD_STATUS);
  // R12: strobes are single-cycle
  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb || stat_stb || data_stb) |=> !(start_stb || stat_stb || data_stb));
endmodule

// File: rtl/hc_status_tx.sv
module hc_status_tx
  import hostcmd_pkg::*;
#(
  parameter logic [31:0] VERSION     = 32'h0001_0000,
  parameter int          REPLY_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] live_in,
  input  logic        cap_done,
  input  logic [31:0] aux_in,
  input  logic        m_ready,
  output logic        m_valid,
  output logic [7:0]  m_data,
  output logic        m_last
);
  localparam int CNT_W  = $clog2(REPLY_BYTES);
  localparam int WIDX_W = CNT_W - 2;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REPLY_BYTES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      snap_live, snap_stat, snap_aux;
  logic [WIDX_W-1:0] widx;
  logic [31:0]      word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      snap_live <= '0;
      snap_stat <= '0;
      snap_aux  <= '0;
    end else if (go && !active) begin
      active    <= 1'b1;
      cnt       <= '0;
      snap_live <= live_in;
      snap_stat <= {30'd0, cap_done, 1'b0};
      snap_aux  <= aux_in;
    end else if (active && m_ready) begin
      if (cnt == CNT_LAST) active <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign widx = cnt[CNT_W-1:2];

  always_comb begin
    unique case (widx)
      WIDX_W'(0): word = REPLY_TAG;
      WIDX_W'(1): word = snap_live;
      WIDX_W'(2): word = snap_stat;
      WIDX_W'(3): word = snap_aux;
      WIDX_W'(4): word = VERSION;
      default:    word = '0;
    endcase
  end

  assign m_valid = active;
  assign m_data  = word[8*cnt[1:0] +: 8];
  assign m_last  = active && (cnt == CNT_LAST);

  // R10: offered byte holds under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
  // R8: reply ends right after its last byte is taken
  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> !m_valid);
  // R8: a request starts the reply on the next cycle
  p_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !m_valid) |=> (m_valid && !m_last));
endmodule

// File: rtl/hostcmd_decoder.sv
module hostcmd_decoder
  import hostcmd_pkg::*;
#(
  parameter logic [31:0] VERSION     = 32'h0001_0000,
  parameter int          REPLY_BYTES = 1024
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  input  logic [7:0]     s_data,
  output logic           s_ready,
  output logic           m_valid,
  output logic [7:0]     m_data,
  output logic           m_last,
  input  logic           m_ready,
  input  logic [31:0]    live_in,
  input  logic           cap_done,
  input  logic [31:0]    aux_in,
  output logic [7:0]     rate_code,
  output logic [7:0]     trig_flags,
  output logic [15:0]    thr_a,
  output logic [15:0]    thr_b,
  output logic [7:0]     aux_param,
  output logic [31:0]    sample_depth,
  output logic [31:0]    pretrig_depth,
  output logic [255:0]   trig1_cfg,
  output logic [255:0]   trig2_cfg,
  output logic           trig1_en,
  output logic           trig2_en,
  output logic           trig_and,
  output logic [15:0]    cmd_code,
  output logic           start_stb,
  output logic           status_stb,
  output logic           data_stb
);
  acq_cfg_t cfg;
  logic     take;

  assign s_ready = !(m_valid || status_stb);
  assign take    = s_valid && s_ready;

  hc_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .in_byte   (s_data),
    .cfg       (cfg),
    .cmd_code  (cmd_code),
    .start_stb (start_stb),
    .stat_stb  (status_stb),
    .data_stb  (data_stb)
  );

  hc_status_tx #(.VERSION(VERSION), .REPLY_BYTES(REPLY_BYTES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (status_stb),
    .live_in  (live_in),
    .cap_done (cap_done),
    .aux_in   (aux_in),
    .m_ready  (m_ready),
    .m_valid  (m_valid),
    .m_data   (m_data),
    .m_last   (m_last)
  );

  assign rate_code     = cfg.rate;
  assign trig_flags    = cfg.flags;
  assign thr_a         = cfg.thr_a;
  assign thr_b         = cfg.thr_b;
  assign aux_param     = cfg.param;
  assign sample_depth  = cfg.depth;
  assign pretrig_depth = cfg.pretrig;
  assign trig1_cfg     = cfg.trig1;
  assign trig2_cfg     = cfg.trig2;
  assign trig1_en      = cfg.flags[0];
  assign trig2_en      = cfg.flags[1];
  assign trig_and      = cfg.flags[2];

  // R12: strobes never overlap
  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_stb, status_stb, data_stb}));
  // R8: a reply only begins after a status strobe
  p_reply_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(status_stb));
  // R6: data and start requests produce no reply
  p_no_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb || start_stb) && !m_valid |=> !m_valid);
endmodule

// File: tb/tb_hostcmd_decoder.sv
module tb_hostcmd_decoder;
  localparam logic [31:0] VER = 32'hC0DE_0107;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, m_valid, m_last;
  logic [7:0] m_data;
  logic m_ready = 1'b1;
  logic [31:0] live_in = '0, aux_in = '0;
  logic cap_done = 1'b0;
  logic [7:0] rate_code, trig_flags, aux_param;
  logic [15:0] thr_a, thr_b, cmd_code;
  logic [31:0] sample_depth, pretrig_depth;
  logic [255:0] trig1_cfg, trig2_cfg;
  logic trig1_en, trig2_en, trig_and, start_stb, status_stb, data_stb;

  always #2 clk = ~clk;

  hostcmd_decoder #(.VERSION(VER), .REPLY_BYTES(1024)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready),
    .live_in(live_in), .cap_done(cap_done), .aux_in(aux_in),
    .rate_code(rate_code), .trig_flags(trig_flags), .thr_a(thr_a), .thr_b(thr_b),
    .aux_param(aux_param), .sample_depth(sample_depth), .pretrig_depth(pretrig_depth),
    .trig1_cfg(trig1_cfg), .trig2_cfg(trig2_cfg), .trig1_en(trig1_en),
    .trig2_en(trig2_en), .trig_and(trig_and), .cmd_code(cmd_code),
    .start_stb(start_stb), .status_stb(status_stb), .data_stb(data_stb));

  int n_checks = 0, n_fail = 0;
  bit bp_mode = 1'b0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]   rbuf[$];
  logic [7:0]   rq[$];
  bit           e_active, e_start, e_stat, e_data, rdy, pend;
  logic [7:0]   e_rate, e_flags, e_param;
  logic [15:0]  e_thra, e_thrb, e_cmd, c;
  logic [31:0]  e_depth, e_pre;
  logic [255:0] e_t1, e_t2;
  logic [31:0]  words[5];

  always @(posedge clk) begin
    if (!rst_n) begin
      rbuf.delete(); rq.delete();
      e_active = 0; e_start = 0; e_stat = 0; e_data = 0;
      e_rate = 0; e_flags = 0; e_param = 0; e_thra = 0; e_thrb = 0;
      e_cmd = 0; e_depth = 0; e_pre = 0; e_t1 = 0; e_t2 = 0;
    end else begin
      rdy = !(e_active || e_stat);
      pend = e_stat;
      e_start = 0; e_stat = 0; e_data = 0;
      if (e_active && m_ready) begin
        void'(rq.pop_front());
        if (rq.size() == 0) e_active = 0;
      end
      if (pend) begin
        words[0] = 32'h2B1A037F; words[1] = live_in;
        words[2] = cap_done ? 32'd2 : 32'd0; words[3] = aux_in; words[4] = VER;
        for (int b = 0; b < 1024; b++)
          rq.push_back(b < 20 ? words[b/4][8*(b%4) +: 8] : 8'h00);
        e_active = 1;
      end
      if (s_valid && rdy) begin
        rbuf.push_back(s_data);
        if (rbuf.size() == 84) begin
          if (rbuf[0] == 8'h7F && rbuf[1] == 8'h01) begin
            c = {rbuf[82], rbuf[83]};
            if (c == 16'h1A2B) begin
              e_start = 1; e_cmd = c;
              e_rate = rbuf[2]; e_flags = rbuf[3];
              e_thra = {rbuf[5], rbuf[4]}; e_thrb = {rbuf[7], rbuf[6]};
              e_param = rbuf[8];
              e_depth = {rbuf[13], rbuf[12], rbuf[11], rbuf[10]};
              e_pre = {rbuf[17], rbuf[16], rbuf[15], rbuf[14]};
              for (int i = 0; i < 32; i++) begin
                e_t1[8*i +: 8] = rbuf[18+i];
                e_t2[8*i +: 8] = rbuf[50+i];
              end
            end else if (c == 16'h3A4B) begin
              e_stat = 1; e_cmd = c;
            end else if (c == 16'h5A6B) begin
              e_data = 1; e_cmd = c;
            end
          end
          rbuf.delete();
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(s_ready == !(e_active || e_stat), "R10 s_ready", s_ready, !(e_active || e_stat));
      chk(m_valid == e_active, "R8 m_valid", m_valid, e_active);
      if (e_active) begin
        chk(m_data == rq[0], "R8/R9 m_data", m_data, rq[0]);
        chk(m_last == (rq.size() == 1), "R8 m_last", m_last, rq.size() == 1);
      end
      chk(start_stb == e_start, "R4 start_stb", start_stb, e_start);
      chk(status_stb == e_stat, "R5 status_stb", status_stb, e_stat);
      chk(data_stb == e_data, "R6 data_stb", data_stb, e_data);
      chk(cmd_code == e_cmd, "R7 cmd_code", cmd_code, e_cmd);
      chk({rate_code, trig_flags, thr_a, thr_b, aux_param} ==
          {e_rate, e_flags, e_thra, e_thrb, e_param}, "R2 small fields",
          {rate_code, trig_flags, thr_a, thr_b, aux_param},
          {e_rate, e_flags, e_thra, e_thrb, e_param});
      chk({sample_depth, pretrig_depth} == {e_depth, e_pre}, "R2 depths",
          {sample_depth, pretrig_depth}, {e_depth, e_pre});
      chk(trig1_cfg == e_t1, "R2 trig1", trig1_cfg, e_t1);
      chk(trig2_cfg == e_t2, "R2 trig2", trig2_cfg, e_t2);
      chk({trig1_en, trig2_en, trig_and} == {e_flags[0], e_flags[1], e_flags[2]},
          "R11 flag decode", {trig1_en, trig2_en, trig_and},
          {e_flags[0], e_flags[1], e_flags[2]});
    end
  end

  always @(negedge clk) m_ready <= bp_mode ? ($urandom % 3 != 0) : 1'b1;

  // ---------------- stimulus ----------------
  logic [7:0] pk[84];

  task automatic make_pkt(input logic [7:0] h0, h1, c0, c1, input int seed);
    for (int i = 0; i < 84; i++) pk[i] = 8'(seed * 31 + i * 13 + 5);
    pk[0] = h0; pk[1] = h1; pk[82] = c0; pk[83] = c1;
  endtask

  task automatic send_pkt(input bit gaps);
    bit hs;
    for (int i = 0; i < 84; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      s_valid = 1'b1; s_data = pk[i];
      do begin hs = s_ready; @(negedge clk); end while (!hs);
    end
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_reply;
    while (e_active || e_stat) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({rate_code, sample_depth, cmd_code} == 0, "R1 reset cfg",
        {rate_code, sample_depth, cmd_code}, 0);
    chk({start_stb, status_stb, data_stb, m_valid} == 0, "R1 reset strobes",
        {start_stb, status_stb, data_stb, m_valid}, 0);
    chk(s_ready == 1'b1, "R1 reset s_ready", s_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    // R2/R4: good start packet, gaps in the stream
    make_pkt(8'h7F, 8'h01, 8'h1A, 8'h2B, 3);
    pk[3] = 8'h05;
    send_pkt(1'b1);
    idle(3);
    chk(thr_a == {pk[5], pk[4]}, "R2 thr_a direct", thr_a, {pk[5], pk[4]});
    chk({trig1_en, trig2_en, trig_and} == 3'b101, "R11 direct", {trig1_en, trig2_en, trig_and}, 3'b101);

    // R5/R8/R9: status request, no back-pressure, inputs change mid-reply
    live_in = 32'hA5A5_1234; aux_in = 32'h0BAD_F00D; cap_done = 1'b0;
    make_pkt(8'h7F, 8'h01, 8'h3A, 8'h4B, 9);
    send_pkt(1'b0);
    idle(4);
    live_in = 32'h0; aux_in = 32'hFFFF_FFFF; cap_done = 1'b1;
    wait_reply();

    // R10: status with back-pressure, next packet queued behind reply
    bp_mode = 1'b1;
    live_in = 32'h1357_9BDF; aux_in = 32'h2468_ACE0;
    make_pkt(8'h7F, 8'h01, 8'h3A, 8'h4B, 11);
    send_pkt(1'b0);
    make_pkt(8'h7F, 8'h01, 8'h1A, 8'h2B, 21);
    pk[3] = 8'h02;
    send_pkt(1'b1);
    wait_reply();
    bp_mode = 1'b0;
    idle(3);

    // R3: bad header with start command (each header byte wrong)
    make_pkt(8'h7E, 8'h01, 8'h1A, 8'h2B, 33);
    send_pkt(1'b0);
    make_pkt(8'h7F, 8'h02, 8'h1A, 8'h2B, 34);
    send_pkt(1'b1);
    idle(3);
    chk(cmd_code == 16'h1A2B && trig_flags == 8'h02, "R3 bad header ignored",
        {cmd_code, trig_flags}, {16'h1A2B, 8'h02});

    // R7: unknown command
    make_pkt(8'h7F, 8'h01, 8'h1A, 8'h4B, 40);
    send_pkt(1'b0);
    idle(3);
    chk(cmd_code == 16'h1A2B, "R7 unknown ignored", cmd_code, 16'h1A2B);

    // R6: data request, no reply
    make_pkt(8'h7F, 8'h01, 8'h5A, 8'h6B, 50);
    send_pkt(1'b1);
    idle(5);
    chk(m_valid == 1'b0 && cmd_code == 16'h5A6B, "R6 data no reply",
        {m_valid, cmd_code}, {1'b0, 16'h5A6B});

    // R12: back-to-back packets, final start with other flags
    make_pkt(8'h7F, 8'h01, 8'h1A, 8'h2B, 60);
    pk[3] = 8'h03;
    send_pkt(1'b0);
    idle(3);

    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule